// File: doc/BRIEF.md
# Paged Segment Address Translator

This block turns a two-part logical address, a segment number plus an offset into that segment, into a physical address. It assumes every segment is split into fixed-size pages. Each segment descriptor holds the segment's length and the position of that segment's own page list inside a shared frame memory. The offset is first checked against the length. If the offset is in range, its upper bits pick an entry in the segment's page list and its lower bits become the byte position inside the page. The chosen frame number and the byte position are then joined to form the physical address.

The requester presents one request at a time with a valid/ready handshake and gets back a single-cycle response. The response carries either a physical address or a trap flag. Both tables are held inside the block. A separate load port writes them, one descriptor or one frame entry per cycle. A translation takes two table reads in sequence, so the block stays busy for several cycles after it accepts a request.

Top module: `pseg_xlate`

## Requirements
- R1: After a synchronous active-low reset, req_ready is 1, rsp_valid is 0 and rsp_paddr is 0.
- R2: A descriptor write on the load port sets a 17-bit segment length and an 8-bit page-list base for one of 16 segments. A frame write sets a 12-bit frame number at one of 256 page-list slots. Every request accepted after the write uses the new contents.
- R3: A request is legal only when its 16-bit offset is strictly less than the segment length. Otherwise the response has rsp_trap = 1 and rsp_paddr = 0.
- R4: The page index is offset bits [15:10], and the byte position inside the page is offset bits [9:0] (1 KB pages).
- R5: The page-list slot read is (base + page index) modulo 256.
- R6: A legal response gives rsp_paddr = frame × 1024 + byte position, as a 22-bit value, with rsp_trap = 0.
- R7: A request is accepted only on a clock edge where both req_valid and req_ready are 1. While the block is busy, req_valid and the request fields have no effect and produce no response.
- R8: rsp_valid rises after the 3rd clock edge that follows the accepting edge for a legal request, and after the 2nd for a trap. It stays high for one cycle, and req_ready returns on the next edge.
- R9: A segment of length 0 traps every offset. A segment of length 65536 accepts every offset, including 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_ready | output | 1 | Block idle, request can be taken |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_trap | output | 1 | Offset out of range |
| rsp_paddr | output | 22 | Physical address, 0 on trap |
| ld_seg_en | input | 1 | Write one segment descriptor |
| ld_seg_idx | input | 4 | Descriptor slot |
| ld_seg_len | input | 17 | Segment length in bytes |
| ld_seg_base | input | 8 | Page-list base slot |
| ld_pt_en | input | 1 | Write one frame entry |
| ld_pt_idx | input | 8 | Frame entry slot |
| ld_pt_frame | input | 12 | Frame number |

## Verification
Offsets on both sides of a segment's length tell a strict compare apart from an inclusive one. Lengths of zero and of the full 64 KB cover the extremes of that compare. Offsets just below and just above a page boundary show whether the index/byte split sits at bit 10. A page-list base near the top of the frame memory shows whether the slot address wraps. Reloading a descriptor and a frame entry between requests shows that later translations see the new values. Junk requests driven while the block is busy show that requests are only taken when it is idle.

// File: rtl/pseg_pkg.sv
// Package: shared types for the paged segment translator.
// Assumes: nothing beyond IEEE 1800-2017.
package pseg_pkg;
    // Translation sequence states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RDSEG = 3'd1,
        ST_CHECK = 3'd2,
        ST_RDPT  = 3'd3,
        ST_DONE  = 3'd4
    } xl_state_t;
endpackage

// File: rtl/pseg_seg_mem.sv
// Segment descriptor store: one length and one page-list base per segment.
// Assumes: read data is registered and updates only while rd_en is high;
// writes come from the load port and may happen in any cycle.
module pseg_seg_mem #(
    parameter int SEG_W  = 4,
    parameter int LEN_W  = 17,
    parameter int BASE_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [BASE_W-1:0] wr_base,
    input  logic              rd_en,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [LEN_W-1:0]  rd_len,
    output logic [BASE_W-1:0] rd_base
);
    localparam int DEPTH = 1 << SEG_W;

    logic [LEN_W-1:0]  len_arr  [DEPTH];
    logic [BASE_W-1:0] base_arr [DEPTH];

    // Write a descriptor from the load port
    always_ff @(posedge clk) begin
        if (wr_en) begin
            len_arr[wr_idx]  <= wr_len;
            base_arr[wr_idx] <= wr_base;
        end
    end

    // Registered descriptor read for the translation sequence
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_len  <= len_arr[rd_idx];
            rd_base <= base_arr[rd_idx];
        end
    end
endmodule

// File: rtl/pseg_pt_mem.sv
// Shared frame memory that holds the page lists of all segments.
// Assumes: read data is registered and updates only while rd_en is high.
module pseg_pt_mem #(
    parameter int IDX_W   = 8,
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [FRAME_W-1:0] rd_frame
);
    localparam int DEPTH = 1 << IDX_W;

    logic [FRAME_W-1:0] frame_arr [DEPTH];

    // Write a frame entry from the load port
    always_ff @(posedge clk) begin
        if (wr_en) frame_arr[wr_idx] <= wr_frame;
    end

    // Registered frame read for the translation sequence
    always_ff @(posedge clk) begin
        if (rd_en) rd_frame <= frame_arr[rd_idx];
    end
endmodule

// File: rtl/pseg_ctrl.sv
// Sequencer: accepts one request, reads the descriptor, checks the offset
// against the length, forms the page-list slot and waits for the frame.
// Assumes: both memories answer one cycle after their read enable.
module pseg_ctrl
    import pseg_pkg::*;
#(
    parameter int SEG_W    = 4,
    parameter int OFF_W    = 16,
    parameter int PG_OFF_W = 10,
    parameter int PT_IDX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [SEG_W-1:0]    req_seg,
    input  logic [OFF_W-1:0]    req_off,
    output logic                req_ready,
    output logic                seg_rd_en,
    output logic [SEG_W-1:0]    seg_rd_idx,
    input  logic [OFF_W:0]      seg_len,
    input  logic [PT_IDX_W-1:0] seg_base,
    output logic                pt_rd_en,
    output logic [PT_IDX_W-1:0] pt_rd_idx,
    output logic                done,
    output logic                trap,
    output logic [PG_OFF_W-1:0] in_page
);
    localparam int PIDX_W = OFF_W - PG_OFF_W;

    xl_state_t          state, nxt;
    logic [SEG_W-1:0]   seg_q;
    logic [OFF_W-1:0]   off_q;
    logic               trap_q;
    logic [PT_IDX_W-1:0] slot_q;
    logic               accept;
    logic               legal;
    logic [PIDX_W-1:0]  page_idx;

    assign accept   = req_valid && (state == ST_IDLE);
    assign legal    = {1'b0, off_q} < seg_len;
    assign page_idx = off_q[OFF_W-1:PG_OFF_W];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state selection; a trap skips the frame read
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (accept) nxt = ST_RDSEG;
            ST_RDSEG: nxt = ST_CHECK;
            ST_CHECK: nxt = legal ? ST_RDPT : ST_DONE;
            ST_RDPT:  nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Capture the request on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
            off_q <= '0;
        end else if (accept) begin
            seg_q <= req_seg;
            off_q <= req_off;
        end
    end

    // Record the range verdict and the page-list slot (wraps modulo depth)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q <= 1'b0;
            slot_q <= '0;
        end else if (state == ST_CHECK) begin
            trap_q <= !legal;
            slot_q <= seg_base + PT_IDX_W'(page_idx);
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign seg_rd_en  = (state == ST_RDSEG);
    assign seg_rd_idx = seg_q;
    assign pt_rd_en   = (state == ST_RDPT);
    assign pt_rd_idx  = slot_q;
    assign done       = (state == ST_DONE);
    assign trap       = trap_q;
    assign in_page    = off_q[PG_OFF_W-1:0];

    // R7
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/pseg_xlate.sv
// Paged segment address translator top: ties the sequencer to the two
// table memories and forms the response.
// Assumes: one request in flight; loads may arrive at any time.
module pseg_xlate #(
    parameter int SEG_W    = 4,
    parameter int OFF_W    = 16,
    parameter int PG_OFF_W = 10,
    parameter int PT_IDX_W = 8,
    parameter int FRAME_W  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [SEG_W-1:0]            req_seg,
    input  logic [OFF_W-1:0]            req_off,
    output logic                        req_ready,
    output logic                        rsp_valid,
    output logic                        rsp_trap,
    output logic [FRAME_W+PG_OFF_W-1:0] rsp_paddr,
    input  logic                        ld_seg_en,
    input  logic [SEG_W-1:0]            ld_seg_idx,
    input  logic [OFF_W:0]              ld_seg_len,
    input  logic [PT_IDX_W-1:0]         ld_seg_base,
    input  logic                        ld_pt_en,
    input  logic [PT_IDX_W-1:0]         ld_pt_idx,
    input  logic [FRAME_W-1:0]          ld_pt_frame
);
    localparam int LEN_W = OFF_W + 1;
    localparam int PA_W  = FRAME_W + PG_OFF_W;

    logic                seg_rd_en, pt_rd_en, done, trap;
    logic [SEG_W-1:0]    seg_rd_idx;
    logic [LEN_W-1:0]    seg_len;
    logic [PT_IDX_W-1:0] seg_base, pt_rd_idx;
    logic [FRAME_W-1:0]  frame;
    logic [PG_OFF_W-1:0] in_page;

    pseg_ctrl #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PG_OFF_W(PG_OFF_W),
                .PT_IDX_W(PT_IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .req_ready(req_ready),
        .seg_rd_en(seg_rd_en), .seg_rd_idx(seg_rd_idx),
        .seg_len(seg_len), .seg_base(seg_base),
        .pt_rd_en(pt_rd_en), .pt_rd_idx(pt_rd_idx),
        .done(done), .trap(trap), .in_page(in_page)
    );

    pseg_seg_mem #(.SEG_W(SEG_W), .LEN_W(LEN_W), .BASE_W(PT_IDX_W)) u_seg (
        .clk(clk),
        .wr_en(ld_seg_en), .wr_idx(ld_seg_idx),
        .wr_len(ld_seg_len), .wr_base(ld_seg_base),
        .rd_en(seg_rd_en), .rd_idx(seg_rd_idx),
        .rd_len(seg_len), .rd_base(seg_base)
    );

    pseg_pt_mem #(.IDX_W(PT_IDX_W), .FRAME_W(FRAME_W)) u_pt (
        .clk(clk),
        .wr_en(ld_pt_en), .wr_idx(ld_pt_idx), .wr_frame(ld_pt_frame),
        .rd_en(pt_rd_en), .rd_idx(pt_rd_idx), .rd_frame(frame)
    );

    // Response: frame joined with in-page bytes, zero on trap or when idle
    always_comb begin
        rsp_valid = done;
        rsp_trap  = done && trap;
        rsp_paddr = (done && !trap) ? {frame, in_page} : '0;
    end

    // R8
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R8
    resp_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);
    // R7
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid);
    // R3
    trap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_paddr == '0) && rsp_valid);
endmodule

// File: tb/sim_pseg_xlate.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected responses, the monitor
// compares them with what the design returns.
module sim_pseg_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic        req_ready, rsp_valid, rsp_trap;
    logic [21:0] rsp_paddr;
    logic        ld_seg_en = 1'b0;
    logic [3:0]  ld_seg_idx = '0;
    logic [16:0] ld_seg_len = '0;
    logic [7:0]  ld_seg_base = '0;
    logic        ld_pt_en = 1'b0;
    logic [7:0]  ld_pt_idx = '0;
    logic [11:0] ld_pt_frame = '0;

    typedef struct {
        logic        trap;
        logic [21:0] pa;
        int          acc;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0, fails = 0, cyc = 0;
    bit          finished = 0;
    logic [16:0] m_len [16];
    logic [7:0]  m_base [16];
    logic [11:0] m_pt [256];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pseg_xlate u0 (.*);

    task automatic load_seg(input int s, input int len, input int base);
        @(negedge clk);
        ld_seg_en = 1; ld_seg_idx = 4'(s); ld_seg_len = 17'(len); ld_seg_base = 8'(base);
        m_len[s] = 17'(len); m_base[s] = 8'(base);
        @(negedge clk);
        ld_seg_en = 0;
    endtask

    task automatic load_pt(input int i, input int f);
        @(negedge clk);
        ld_pt_en = 1; ld_pt_idx = 8'(i); ld_pt_frame = 12'(f);
        m_pt[i] = 12'(f);
        @(negedge clk);
        ld_pt_en = 0;
    endtask

    // Drive one request and push its expected response (R3 R4 R5 R6)
    task automatic request(input int s, input int off, input string tag, input bit junk);
        exp_t e;
        logic [15:0] o;
        logic [7:0]  slot;
        o = 16'(off);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_seg = 4'(s); req_off = o;
        e.acc = cyc + 1;
        e.tag = tag;
        if ({1'b0, o} >= m_len[s]) begin
            e.trap = 1; e.pa = '0;
        end else begin
            slot = m_base[s] + {2'b00, o[15:10]};
            e.trap = 0; e.pa = {m_pt[slot], o[9:0]};
        end
        q.push_back(e);
        @(negedge clk);
        if (junk) begin
            // R7: busy, these must be ignored
            req_seg = 4'(s ^ 1); req_off = ~o;
            repeat (2) @(negedge clk);
        end
        req_valid = 0;
    endtask

    // Monitor: compare every response against the queue (R8 latency)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t e;
            int   lat, elat;
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R7: unexpected response trap=%0b paddr=%h, expected none",
                         rsp_trap, rsp_paddr);
            end else begin
                e = q.pop_front();
                lat = cyc - e.acc;
                elat = e.trap ? 2 : 3;
                if (rsp_trap !== e.trap || rsp_paddr !== e.pa || lat != elat) begin
                    fails++;
                    $display("FAIL %s: trap=%0b paddr=%h lat=%0d expected trap=%0b paddr=%h lat=%0d",
                             e.tag, rsp_trap, rsp_paddr, lat, e.trap, e.pa, elat);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        // R1
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || rsp_paddr !== '0) begin
            fails++;
            $display("FAIL R1: ready=%0b valid=%0b paddr=%h expected 1 0 0",
                     req_ready, rsp_valid, rsp_paddr);
        end

        load_seg(15, 5096, 32);
        load_pt(35, 12);
        load_pt(36, 7);
        load_seg(1, 2048, 100);
        load_pt(100, 1);
        load_pt(101, 2);
        load_seg(2, 0, 0);
        load_seg(3, 65536, 250);
        load_pt(57, 12'hABC);
        load_pt(4, 12'hFFF);

        request(15, 3921, "R6 worked example", 0);
        request(15, 5095, "R3 last legal byte", 0);
        request(15, 5096, "R3 offset equals length", 0);
        request(15, 60000, "R3 far beyond length", 0);
        request(1, 1023, "R4 top of page 0", 0);
        request(1, 1024, "R4 start of page 1", 0);
        request(2, 0, "R9 zero length", 0);
        request(3, 16'hFFFF, "R9 full length", 0);
        request(3, 10245, "R5 slot wrap", 0);
        request(15, 0, "R7 junk while busy", 1);
        load_seg(1, 500, 100);
        load_pt(100, 9);
        request(1, 1023, "R2 shortened segment", 0);
        request(1, 499, "R2 new frame", 0);

        repeat (10) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R8: %0d responses missing, expected 0", q.size());
        end
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R8: watchdog expired, actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule